// File: doc/BRIEF.md
# Bit-Serial Microcoded Datapath Core

This core keeps its whole working state in three shift registers and is steered by a microcode sequencer. The address register (16 bits) drives the RAM address port. The data register (16 bits) holds the accumulator in its low byte and the store data in its high byte. The buffer register (8 bits) receives bytes read from RAM. Every register moves one bit per clock, from its top bit toward bit 0, and only when its microinstruction bit asks for it.

Each clock, a 13-bit table address is formed from the current microstate and five live condition bits. These are the lowest bit of each of the three registers and the two external input pins. That address reads an 8-bit control word and an 8-bit successor state from two writable arrays. Branching is therefore nothing more than table contents, and no condition logic is needed. A table-load port fills both arrays while the datapath and sequencer are frozen. Once the load port is released, the core runs whatever microprogram was written.

Top module: `bitser_core`

## Requirements
- R1: While rst_n is low, the address, data and buffer registers, the output latch and the microstate are all zero. Assertion is asynchronous and release takes effect two clock edges later.
- R2: Control bit 0 shifts the data register one place toward bit 0, and control bit 1 becomes its new bit 15. ram_wdata always shows data bits 15:8.
- R3: Control bit 2 shifts the address register the same way, with control bit 3 as its new bit 15. ram_addr always shows the address register.
- R4: Control bit 5 captures ram_rdata, read combinationally at the current ram_addr, into the buffer register at the next edge. If bit 4 is also set, the load wins.
- R5: Control bit 4 without bit 5 shifts the buffer register toward bit 0 and fills bit 7 with 0.
- R6: Control bit 6 raises ram_we in the same cycle, so the external RAM writes ram_wdata at ram_addr on that edge. If bits 5 and 6 are both set, the buffer receives the byte held before the write.
- R7: Control bit 7 copies data bits 7:0 into out_latch at the edge. Otherwise out_latch holds its value.
- R8: The table address is {microstate[7:0], in_bits[1], in_bits[0], buffer bit 0, address bit 0, data bit 0}, with data bit 0 at position 0. On every running edge the microstate takes the successor entry at that address.
- R9: While tbl_load is high, tbl_ctl and tbl_next are written at tbl_addr on each edge. The microstate and all registers hold, and ram_we stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| tbl_load | input | 1 | Table write enable; freezes the core |
| tbl_addr | input | 13 | Table write address |
| tbl_ctl | input | 8 | Control word to write |
| tbl_next | input | 8 | Successor state to write |
| in_bits | input | 2 | External condition inputs |
| ram_addr | output | 16 | RAM address (address register) |
| ram_rdata | input | 8 | RAM read data, combinational |
| ram_wdata | output | 8 | RAM write data (data bits 15:8) |
| ram_we | output | 1 | RAM write strobe |
| out_latch | output | 8 | Output latch |
| ustate | output | 8 | Current microstate |

## Verification
A read into the buffer register and a write of the data register's high byte can both be requested in one control word. That is the case where ordering matters. The bench's microprogram sets both bits in a single state after preloading the addressed RAM byte with a value different from the store data. It then judges the result in two ways. The RAM byte must afterwards hold the store data. The buffer must hold the preloaded byte, which the next eight states shift into the address register, where it is read back on ram_addr.

// File: rtl/bitser_pkg.sv
package bitser_pkg;
  localparam int unsigned CTL_W   = 8;
  localparam int unsigned STATE_W = 8;
  localparam int unsigned COND_W  = 5;
  localparam int unsigned TAD_W   = STATE_W + COND_W;

  // Control word, bit 0 at the bottom of the struct.
  typedef struct packed {
    logic io_cp;     // 7
    logic st_en;     // 6
    logic ld_en;     // 5
    logic bsh;       // 4
    logic a_bit;     // 3
    logic ash;       // 2
    logic x_bit;     // 1
    logic xsh;       // 0
  } uword_t;
endpackage

// File: rtl/bitser_rst_sync.sv
module bitser_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ok = sync_q[1];
endmodule

// File: rtl/bitser_shreg.sv
module bitser_shreg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         shift_in,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load_en)       q_nxt = load_val;
    else if (shift_en) q_nxt = {shift_in, q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/bitser_useq.sv
module bitser_useq
  import bitser_pkg::*;
#(
  parameter int unsigned SW = STATE_W,
  parameter int unsigned CW = COND_W,
  parameter int unsigned KW = CTL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [CW-1:0]   cond,
  input  logic            wr_en,
  input  logic [SW+CW-1:0] wr_addr,
  input  logic [KW-1:0]   wr_ctl,
  input  logic [SW-1:0]   wr_next,
  output logic [KW-1:0]   ctl,
  output logic [SW-1:0]   state
);
  localparam int unsigned AW    = SW + CW;
  localparam int unsigned DEPTH = 1 << AW;

  logic [KW-1:0] ctl_mem [DEPTH];
  logic [SW-1:0] nxt_mem [DEPTH];
  logic [AW-1:0] rd_addr;
  logic [SW-1:0] state_nxt;

  assign rd_addr = {state, cond};
  assign ctl     = ctl_mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ctl_mem[wr_addr] <= wr_ctl;
      nxt_mem[wr_addr] <= wr_next;
    end
  end

  always_comb begin
    state_nxt = state;
    if (run) state_nxt = nxt_mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= '0;
    else        state <= state_nxt;
  end
endmodule

// File: rtl/bitser_core.sv
module bitser_core
  import bitser_pkg::*;
#(
  parameter int unsigned AW_REG = 16,
  parameter int unsigned XW_REG = 16,
  parameter int unsigned DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_load,
  input  logic [TAD_W-1:0]  tbl_addr,
  input  logic [CTL_W-1:0]  tbl_ctl,
  input  logic [STATE_W-1:0] tbl_next,
  input  logic [1:0]        in_bits,
  output logic [AW_REG-1:0] ram_addr,
  input  logic [DW-1:0]     ram_rdata,
  output logic [DW-1:0]     ram_wdata,
  output logic              ram_we,
  output logic [DW-1:0]     out_latch,
  output logic [STATE_W-1:0] ustate
);
  logic              rst_ok;
  logic              run;
  logic [CTL_W-1:0]  uins;
  uword_t            uw;
  logic [XW_REG-1:0] x_q;
  logic [AW_REG-1:0] a_q;
  logic [DW-1:0]     t_q;
  logic [DW-1:0]     lat_nxt;
  logic [COND_W-1:0] cond;

  bitser_rst_sync u_rsync (.clk(clk), .rst_n(rst_n), .rst_ok(rst_ok));

  assign run  = rst_ok & ~tbl_load;
  assign uw   = uword_t'(uins);
  assign cond = {in_bits[1], in_bits[0], t_q[0], a_q[0], x_q[0]};

  bitser_useq u_seq (
    .clk     (clk),
    .rst_n   (rst_ok),
    .run     (run),
    .cond    (cond),
    .wr_en   (tbl_load),
    .wr_addr (tbl_addr),
    .wr_ctl  (tbl_ctl),
    .wr_next (tbl_next),
    .ctl     (uins),
    .state   (ustate)
  );

  bitser_shreg #(.W(XW_REG)) u_xreg (
    .clk(clk), .rst_n(rst_ok), .shift_en(run & uw.xsh), .shift_in(uw.x_bit),
    .load_en(1'b0), .load_val('0), .q(x_q)
  );

  bitser_shreg #(.W(AW_REG)) u_areg (
    .clk(clk), .rst_n(rst_ok), .shift_en(run & uw.ash), .shift_in(uw.a_bit),
    .load_en(1'b0), .load_val('0), .q(a_q)
  );

  bitser_shreg #(.W(DW)) u_treg (
    .clk(clk), .rst_n(rst_ok), .shift_en(run & uw.bsh), .shift_in(1'b0),
    .load_en(run & uw.ld_en), .load_val(ram_rdata), .q(t_q)
  );

  assign ram_addr  = a_q;
  assign ram_wdata = x_q[XW_REG-1 -: DW];
  assign ram_we    = run & uw.st_en;

  always_comb begin
    lat_nxt = out_latch;
    if (run && uw.io_cp) lat_nxt = x_q[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) out_latch <= '0;
    else         out_latch <= lat_nxt;
  end
endmodule

// File: rtl/bitser_core_chk.sv
module bitser_core_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic        run,
  input logic [7:0]  uins,
  input logic [15:0] ram_addr,
  input logic [7:0]  ram_rdata,
  input logic        ram_we,
  input logic [7:0]  out_latch,
  input logic [7:0]  ustate,
  input logic [15:0] x_q,
  input logic [7:0]  t_q
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    !run |=> ($stable(ustate) && $stable(ram_addr) && $stable(x_q) && $stable(t_q)));

  assert_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    !run |-> !ram_we);

  assert_xshift_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (run && uins[0]) |=> (x_q == {$past(uins[1]), $past(x_q[15:1])}));

  assert_ashift_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (run && uins[2]) |=> (ram_addr == {$past(uins[3]), $past(ram_addr[15:1])}));

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (run && uins[5]) |=> (t_q == $past(ram_rdata)));

  assert_tfill_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (run && uins[4] && !uins[5]) |=> (t_q == {1'b0, $past(t_q[7:1])}));

  assert_latch_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (run && uins[7]) |=> (out_latch == $past(x_q[7:0])));

  assert_latchkeep_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (run && !uins[7]) |=> $stable(out_latch));
endmodule

bind bitser_core bitser_core_chk u_chk (
  .clk(clk), .rst_ok(rst_ok), .run(run), .uins(uins), .ram_addr(ram_addr),
  .ram_rdata(ram_rdata), .ram_we(ram_we), .out_latch(out_latch),
  .ustate(ustate), .x_q(x_q), .t_q(t_q)
);

// File: tb/bitser_core_bench.sv
module bitser_core_bench;
  localparam logic [15:0] XK = 16'hA5C3;
  localparam logic [15:0] AK = 16'h1234;
  // {preloaded RAM byte, expected latch, expected stored byte, expected addr high}
  localparam logic [31:0] VEC [4] = '{32'h3CC3A53C, 32'h81C3A581,
                                      32'hFFC3A5FF, 32'h00C3A500};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tbl_load;
  logic [12:0] tbl_addr;
  logic [7:0]  tbl_ctl, tbl_next;
  logic [1:0]  in_bits;
  logic [15:0] ram_addr;
  logic [7:0]  ram_rdata, ram_wdata, out_latch, ustate;
  logic        ram_we;
  logic [7:0]  mem [256];
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bitser_core u_bitser_core (
    .clk(clk), .rst_n(rst_n), .tbl_load(tbl_load), .tbl_addr(tbl_addr),
    .tbl_ctl(tbl_ctl), .tbl_next(tbl_next), .in_bits(in_bits),
    .ram_addr(ram_addr), .ram_rdata(ram_rdata), .ram_wdata(ram_wdata),
    .ram_we(ram_we), .out_latch(out_latch), .ustate(ustate)
  );

  assign ram_rdata = mem[ram_addr[7:0]];
  always @(posedge clk) if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;

  // Microprogram: {ctl, next} for a table address.
  function automatic logic [15:0] uprog(input logic [12:0] ad);
    logic [7:0] s, c, n;
    logic x0, t0, i0, i1;
    s = ad[12:5]; x0 = ad[0]; t0 = ad[2]; i0 = ad[3]; i1 = ad[4];
    c = 8'h00; n = s;
    if (s == 0) n = (i0 && i1) ? 8'd1 : 8'd0;
    else if (s <= 16) begin
      c = {4'b0000, AK[s-1], 1'b1, XK[s-1], 1'b1};
      n = s + 8'd1;
    end else if (s == 17) begin
      c = 8'hE0; n = 8'd18;
    end else if (s <= 25) begin
      c = {4'b0001, t0, 1'b1, 2'b00};
      n = s + 8'd1;
    end else if (s == 26) n = t0 ? 8'd30 : (x0 ? 8'd27 : 8'd29);
    else if (s == 27) n = (i1 && !i0) ? 8'd0 : 8'd27;
    return {c, n};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_start;
    in_bits = 2'b11;
    step(1);
    in_bits = 2'b00;
  endtask

  task automatic go_idle;
    in_bits = 2'b10;
    step(1);
    in_bits = 2'b00;
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] held_addr;
    rst_n = 1'b0; tbl_load = 1'b0; tbl_addr = '0; tbl_ctl = '0; tbl_next = '0;
    in_bits = 2'b00;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    step(2);
    tbl_load = 1'b1;
    for (int a = 0; a < 8192; a++) begin
      tbl_addr = 13'(a);
      {tbl_ctl, tbl_next} = uprog(13'(a));
      step(1);
    end
    tbl_load = 1'b0;
    rst_n = 1'b1;
    step(3);
    chk("R1 state", 32'(ustate), 0);
    chk("R1 addr", 32'(ram_addr), 0);
    chk("R1 wdata", 32'(ram_wdata), 0);
    chk("R1 latch", 32'(out_latch), 0);
    chk("R1 we", 32'(ram_we), 0);

    // R8: only in_bits == 11 leaves state 0
    in_bits = 2'b01; step(3);
    chk("R8 in01 holds", 32'(ustate), 0);
    in_bits = 2'b10; step(3);
    chk("R8 in10 holds", 32'(ustate), 0);
    in_bits = 2'b00;

    for (int v = 0; v < 4; v++) begin
      mem[AK[7:0]] = VEC[v][31:24];
      go_start;
      chk("R8 start", 32'(ustate), 1);
      step(16);
      chk("R8 state17", 32'(ustate), 17);
      chk("R3 addr after 16 shifts", 32'(ram_addr), 32'(AK));
      chk("R2 wdata after 16 shifts", 32'(ram_wdata), 32'(XK[15:8]));
      chk("R6 store strobe", 32'(ram_we), 1);
      step(10);
      chk("R5 R8 reached 27 (buffer zero-filled)", 32'(ustate), 27);
      chk("R7 latch", 32'(out_latch), 32'(VEC[v][23:16]));
      chk("R6 stored byte", 32'(mem[AK[7:0]]), 32'(VEC[v][15:8]));
      chk("R4 R6 buffer got pre-write byte", 32'(ram_addr), {16'h0, VEC[v][7:0], AK[15:8]});
      in_bits = 2'b01; step(2);
      chk("R8 in01 keeps 27", 32'(ustate), 27);
      go_idle;
      chk("R8 in10 returns 0", 32'(ustate), 0);
    end

    // R9: table write mid-run freezes everything
    mem[AK[7:0]] = 8'h5A;
    go_start;
    step(4);
    chk("R9 at state5", 32'(ustate), 5);
    held_addr = ram_addr;
    tbl_load = 1'b1;
    tbl_addr = {8'd5, 5'b00000};
    {tbl_ctl, tbl_next} = uprog({8'd5, 5'b00000});
    @(posedge clk); #1;
    chk("R9 we low during load", 32'(ram_we), 0);
    step(4);
    chk("R9 state held", 32'(ustate), 5);
    chk("R9 addr held", 32'(ram_addr), 32'(held_addr));
    tbl_load = 1'b0;
    step(22);
    chk("R9 resumed to 27", 32'(ustate), 27);
    chk("R9 resumed addr", 32'(ram_addr), 32'h5A12);
    go_idle;

    // R1: asynchronous reset mid-run
    go_start;
    step(9);
    rst_n = 1'b0; #1;
    chk("R1 async state", 32'(ustate), 0);
    chk("R1 async addr", 32'(ram_addr), 0);
    chk("R1 async latch", 32'(out_latch), 0);
    step(1);
    rst_n = 1'b1;
    step(3);
    chk("R1 after release", 32'(ustate), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule